// File: doc/BRIEF.md
# Byte-wide SPI host for an SD card socket

The block sits on a narrow CPU bus and talks to one SD card in SPI mode through two byte registers. Offset 0 is written to set up the link and read to learn its state. Offset 1 moves data. A write to offset 1 sends that byte to the card. A read from offset 1 returns the byte captured by the last finished exchange, and it also starts a new exchange that sends all ones. Software can therefore clock a response out of the card with a series of reads and no writes.

The block drives SCLK, MOSI and an active-low card select, and it samples MISO. Status reads pass the card-present and write-protect pins straight through. An optional interrupt flag marks the end of each exchange. With the link enabled and the slot select clear, exchanges still toggle SCLK while the card stays deselected. This gives the card the dummy clocks it needs at power-up.

Top module: `spi_byte_host`

## Requirements
- R1: A control write (req_i=1, we_i=1, addr_i=0) loads bit 7 as link enable, bit 6 as interrupt enable and bit 0 as slot select. Bits 5 to 1 are ignored, and 8'h3E has the same effect as 8'h00.
- R2: A status read (req_i=1, we_i=0, addr_i=0) presents {irq flag, 5'b0, card_wp_i, card_det_i} on rdata_o in the same cycle.
- R3: A data write (addr_i=1) sends wdata_i MSB first with 8 SCLK pulses in SPI mode 0. SCLK idles low, MOSI changes only after a falling edge, and MISO is sampled on the rising SCLK edge.
- R4: A data read (addr_i=1, we_i=0) shows the last received byte on rdata_o in the same cycle and starts an exchange that sends 8'hFF.
- R5: cs_n_o equals NOT(enable AND slot select). It is updated only on clock edges at which no exchange is in progress, one cycle after the control register changes. With the slot select clear, exchanges pulse SCLK while cs_n_o stays high.
- R6: An exchange occupies 16 clk_i cycles, with SCLK high for one cycle and low for one cycle per bit. A data access at the 16th edge after the accepting edge is ignored. A data access at the 17th edge is accepted.
- R7: When an exchange finishes with interrupt enable set, the irq flag (irq_o, status bit 7) sets. A status read clears it. If both happen at the same edge, the set wins.
- R8: A data access that arrives during an exchange is ignored. It does not alter the bits being shifted out or the received byte.
- R9: While link enable is clear, data accesses start no exchange and SCLK stays low. A data read still returns the last received byte.
- R10: After reset, cs_n_o=1, sclk_o=0, mosi_o=1, irq_o=0, and the received-byte register reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 1 | 0 = control/status, 1 = data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| card_det_i | input | 1 | Card present pin, 1 = present |
| card_wp_i | input | 1 | Write-protect pin, 1 = locked |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data to card |
| miso_i | input | 1 | Serial data from card |
| cs_n_o | output | 1 | Active-low card select |
| irq_o | output | 1 | Interrupt flag |

## Verification
The assertions assume that the bus strobe lasts exactly one clock per access and that req_i, we_i and addr_i are stable around each rising edge. The bench meets this by changing every bus input 2 ns after an edge and dropping req_i after one cycle.

The assertions also assume the card changes MISO only after falling SCLK edges. The bench card model shifts its byte on sclk_o's falling edge and loads a new byte only while no exchange is running, so each sampled bit is settled one full cycle before the rising edge that captures it.

// File: rtl/spi_byte_host_pkg.sv
package spi_byte_host_pkg;
  localparam int BYTE_W   = 8;
  localparam int EN_BIT   = 7;
  localparam int IE_BIT   = 6;
  localparam int SLOT_BIT = 0;
  localparam int WP_BIT   = 1;
  localparam int CD_BIT   = 0;
  localparam int IRQ_BIT  = 7;

  typedef struct packed {
    logic en;
    logic ie;
    logic slot;
  } ctrl_t;
endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] tx_byte_i,
  input  logic         miso_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] rx_byte_o,
  output logic         sclk_o,
  output logic         mosi_o
);
  localparam int STEPS = 2 * W;
  localparam int CNT_W = $clog2(STEPS) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     tx_sh_q, rx_sh_q, rx_q;
  logic             sclk_q;

  assign busy_o    = (cnt_q != '0);
  assign done_o    = busy_o && !cnt_q[0] && (cnt_q == CNT_W'(STEPS));
  assign rx_byte_o = rx_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = tx_sh_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      tx_sh_q <= '1;
      rx_sh_q <= '1;
      rx_q    <= '1;
      sclk_q  <= 1'b0;
    end else if (!busy_o) begin
      if (start_i) begin
        cnt_q   <= CNT_W'(1);
        tx_sh_q <= tx_byte_i;
        sclk_q  <= 1'b0;
      end
    end else if (cnt_q[0]) begin
      // rising half: sample MISO
      sclk_q  <= 1'b1;
      rx_sh_q <= {rx_sh_q[W-2:0], miso_i};
      cnt_q   <= cnt_q + 1'b1;
    end else begin
      // falling half: advance MOSI, idle fill with ones
      sclk_q  <= 1'b0;
      tx_sh_q <= {tx_sh_q[W-2:0], 1'b1};
      if (done_o) begin
        cnt_q <= '0;
        rx_q  <= rx_sh_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
  import spi_byte_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  ctrl_t             ctrl_d_i,
  input  logic              stat_rd_i,
  input  logic              done_i,
  input  logic              busy_i,
  input  logic              card_det_i,
  input  logic              card_wp_i,
  output ctrl_t             ctrl_o,
  output logic              irq_o,
  output logic              cs_n_o,
  output logic [BYTE_W-1:0] status_o
);
  ctrl_t ctrl_q;
  logic  irq_q, cs_n_q;

  assign ctrl_o = ctrl_q;
  assign irq_o  = irq_q;
  assign cs_n_o = cs_n_q;

  always_comb begin
    status_o          = '0;
    status_o[IRQ_BIT] = irq_q;
    status_o[WP_BIT]  = card_wp_i;
    status_o[CD_BIT]  = card_det_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
      cs_n_q <= 1'b1;
    end else begin
      if (ctrl_wr_i) ctrl_q <= ctrl_d_i;
      // set beats clear
      if (done_i && ctrl_q.ie) irq_q <= 1'b1;
      else if (stat_rd_i)      irq_q <= 1'b0;
      if (!busy_i) cs_n_q <= !(ctrl_q.en && ctrl_q.slot);
    end
  end
endmodule

// File: rtl/spi_byte_host.sv
module spi_byte_host
  import spi_byte_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              card_det_i,
  input  logic              card_wp_i,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_n_o,
  output logic              irq_o
);
  ctrl_t             ctrl_q, ctrl_d;
  logic              ctrl_wr, stat_rd, data_acc, start;
  logic              eng_busy, eng_done;
  logic [BYTE_W-1:0] tx_byte, rx_byte, status;

  assign ctrl_wr  = req_i && we_i && !addr_i;
  assign stat_rd  = req_i && !we_i && !addr_i;
  assign data_acc = req_i && addr_i;
  assign start    = data_acc && ctrl_q.en;
  assign tx_byte  = we_i ? wdata_i : '1;
  assign ctrl_d   = '{en: wdata_i[EN_BIT], ie: wdata_i[IE_BIT], slot: wdata_i[SLOT_BIT]};
  assign rdata_o  = addr_i ? rx_byte : status;

  spi_ctrl_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_wr_i  (ctrl_wr),
    .ctrl_d_i   (ctrl_d),
    .stat_rd_i  (stat_rd),
    .done_i     (eng_done),
    .busy_i     (eng_busy),
    .card_det_i (card_det_i),
    .card_wp_i  (card_wp_i),
    .ctrl_o     (ctrl_q),
    .irq_o      (irq_o),
    .cs_n_o     (cs_n_o),
    .status_o   (status)
  );

  spi_shift_engine #(.W(BYTE_W)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .tx_byte_i (tx_byte),
    .miso_i    (miso_i),
    .busy_o    (eng_busy),
    .done_o    (eng_done),
    .rx_byte_o (rx_byte),
    .sclk_o    (sclk_o),
    .mosi_o    (mosi_o)
  );
endmodule

// File: rtl/spi_byte_host_chk.sv
module spi_byte_host_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic       addr_i,
  input logic [7:0] rdata_o,
  input logic       sclk_o,
  input logic       cs_n_o,
  input logic       irq_o,
  input logic       busy,
  input logic       done,
  input logic       ctrl_en
);
  // R5
  cs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(cs_n_o));

  // R5
  cs_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_en && !busy) |=> cs_n_o);

  // R3
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !sclk_o);

  // R9
  no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i && !ctrl_en && !busy) |=> !busy);

  // R7
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !addr_i && !done) |=> !irq_o);

  // R2
  stat_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !addr_i) |-> (rdata_o[6:2] == 5'b0));
endmodule

bind spi_byte_host spi_byte_host_chk chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .sclk_o  (sclk_o),
  .cs_n_o  (cs_n_o),
  .irq_o   (irq_o),
  .busy    (eng_busy),
  .done    (eng_done),
  .ctrl_en (ctrl_q.en)
);

// File: tb/spi_byte_host_tb_top.sv
`timescale 1ns/1ps
module spi_byte_host_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0, we_i = 1'b0, addr_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       card_det_i = 1'b0, card_wp_i = 1'b0;
  logic       sclk_o, mosi_o, miso_i, cs_n_o, irq_o;

  int checks = 0, fails = 0;

  always #5 clk_i = ~clk_i;

  spi_byte_host dut_i (.*);

  // card model: shifts on falling SCLK
  logic [7:0] card_sh = 8'hFF;
  assign miso_i = card_sh[7];
  always @(negedge sclk_o) card_sh <= {card_sh[6:0], 1'b1};

  // MOSI capture on rising SCLK
  logic [7:0] mosi_cap = 8'h00;
  int         rises = 0;
  always @(posedge sclk_o) begin
    mosi_cap <= {mosi_cap[6:0], mosi_o};
    rises    <= rises + 1;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int         m_cnt;
  logic [7:0] m_tx, m_rxsh, m_rx;
  bit         m_en, m_ie, m_slot, m_irq, m_cs_n, m_sclk;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_tx = 8'hFF; m_rxsh = 8'hFF; m_rx = 8'hFF;
      m_en = 0; m_ie = 0; m_slot = 0; m_irq = 0; m_cs_n = 1; m_sclk = 0;
    end else begin
      bit old_busy, oen, oslot, oie, done;
      old_busy = (m_cnt != 0); oen = m_en; oslot = m_slot; oie = m_ie; done = 0;
      if (old_busy) begin
        if (m_cnt % 2 == 1) begin
          m_sclk = 1; m_rxsh = {m_rxsh[6:0], miso_i}; m_cnt++;
        end else begin
          m_sclk = 0; m_tx = {m_tx[6:0], 1'b1};
          if (m_cnt == 16) begin m_cnt = 0; m_rx = m_rxsh; done = 1; end
          else m_cnt++;
        end
      end
      if (req_i && we_i && !addr_i) begin
        m_en = wdata_i[7]; m_ie = wdata_i[6]; m_slot = wdata_i[0];
      end
      if (req_i && !we_i && !addr_i) m_irq = 0;
      if (done && oie) m_irq = 1;
      if (!old_busy) begin
        m_cs_n = !(oen && oslot);
        if (req_i && addr_i && oen) begin
          m_cnt = 1; m_tx = we_i ? wdata_i : 8'hFF; m_sclk = 0;
        end
      end
    end
  end

  // per-cycle comparison, mid-cycle
  always @(negedge clk_i) begin
    if (rst_ni) begin
      check("R3 sclk",  {7'b0, sclk_o}, {7'b0, m_sclk});
      check("R3 mosi",  {7'b0, mosi_o}, {7'b0, m_tx[7]});
      check("R5 cs_n",  {7'b0, cs_n_o}, {7'b0, m_cs_n});
      check("R7 irq",   {7'b0, irq_o},  {7'b0, m_irq});
      check("R2 R4 rdata", rdata_o,
            addr_i ? m_rx : {m_irq, 5'b0, card_wp_i, card_det_i});
    end
  end

  // bus tasks: called and return at posedge+2
  task automatic bus_wr(input logic a, input logic [7:0] d);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #2;
    req_i = 0; we_i = 0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    req_i = 1; we_i = 0; addr_i = a;
    #3 d = rdata_o;
    @(posedge clk_i); #2;
    req_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int r0;
    idle(3);
    rst_ni = 1;
    #1;
    // R10 reset state
    check("R10 cs_n", {7'b0, cs_n_o}, 8'h01);
    check("R10 sclk", {7'b0, sclk_o}, 8'h00);
    check("R10 mosi", {7'b0, mosi_o}, 8'h01);
    check("R10 irq",  {7'b0, irq_o},  8'h00);
    idle(1);
    bus_rd(1, d);
    check("R10 rx byte", d, 8'hFF);

    // R2 status pins
    card_det_i = 1; card_wp_i = 0;
    bus_rd(0, d); check("R2 status present", d, 8'h01);
    card_wp_i = 1;
    bus_rd(0, d); check("R2 status locked", d, 8'h03);
    card_det_i = 0;
    bus_rd(0, d); check("R2 status wp only", d, 8'h02);

    // R1 / R9: bits 5..1 alone do not enable
    bus_wr(0, 8'h3E); idle(2);
    r0 = rises;
    bus_wr(1, 8'h55); idle(20);
    check("R1 R9 no clocks while disabled", 8'(rises - r0), 8'h00);
    check("R1 cs_n high", {7'b0, cs_n_o}, 8'h01);
    bus_rd(1, d); check("R9 rx byte kept", d, 8'hFF);

    // R5 dummy clocks with card deselected
    bus_wr(0, 8'h80); idle(2);
    r0 = rises;
    bus_wr(1, 8'hFF); idle(8);
    check("R5 cs_n high mid-transfer", {7'b0, cs_n_o}, 8'h01);
    idle(12);
    check("R5 eight dummy pulses", 8'(rises - r0), 8'h08);

    // R3 write MSB first, R5 select asserted
    bus_wr(0, 8'h81); idle(2);
    check("R5 cs_n low", {7'b0, cs_n_o}, 8'h00);
    card_sh = 8'h3C;
    r0 = rises;
    bus_wr(1, 8'hA5); idle(20);
    check("R3 mosi byte", mosi_cap, 8'hA5);
    check("R3 eight pulses", 8'(rises - r0), 8'h08);

    // R4 read returns received byte and sends FF
    card_sh = 8'hC3;
    bus_rd(1, d); check("R4 returns last byte", d, 8'h3C);
    idle(20);
    check("R4 dummy sent ones", mosi_cap, 8'hFF);
    bus_rd(1, d); check("R4 second byte", d, 8'hC3);
    idle(20);

    // R6 boundary: 16th edge ignored, 17th accepted
    r0 = rises;
    bus_wr(1, 8'h81); idle(15);
    bus_wr(1, 8'h42); idle(20);
    check("R6 access at edge 16 ignored", 8'(rises - r0), 8'h08);
    check("R6 first byte intact", mosi_cap, 8'h81);
    r0 = rises;
    bus_wr(1, 8'h81); idle(16);
    bus_wr(1, 8'h42); idle(20);
    check("R6 access at edge 17 accepted", 8'(rises - r0), 8'h10);
    check("R6 second byte sent", mosi_cap, 8'h42);

    // R8 writes and reads during a transfer are ignored
    card_sh = 8'h96;
    bus_wr(1, 8'h5A); idle(3);
    bus_wr(1, 8'h00);
    bus_rd(1, d); idle(20);
    check("R8 mosi unchanged", mosi_cap, 8'h5A);
    bus_rd(1, d); check("R8 rx unchanged", d, 8'h96);
    idle(20);

    // R7 irq set, status read clears
    bus_wr(0, 8'hC1); idle(2);
    bus_wr(1, 8'h11); idle(20);
    check("R7 irq set", {7'b0, irq_o}, 8'h01);
    bus_rd(0, d); check("R7 status bit7", d & 8'h80, 8'h80);
    check("R7 irq cleared", {7'b0, irq_o}, 8'h00);
    // R7 set wins over simultaneous clear: read status at edge 16
    bus_wr(1, 8'h22); idle(15);
    bus_rd(0, d);
    check("R7 set beats clear", {7'b0, irq_o}, 8'h01);
    bus_rd(0, d);

    // R5 disable releases select
    bus_wr(0, 8'h00); idle(2);
    check("R5 cs_n released", {7'b0, cs_n_o}, 8'h01);
    check("R7 irq clear at end", {7'b0, irq_o}, 8'h00);

    idle(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule